// File: doc/BRIEF.md
# Configurable D/T/JK Logic Cell

This block is one cell of a programmable logic fabric. It receives four sum-of-products terms from an external AND/OR array, called sum A, B, C and D. Static configuration inputs decide what each term does. A term can be the data input of a single storage element. It can also be a control for that element (clock, preset, reset, or output enable), or it can pass straight to an output. The storage element behaves as a D, T or JK flip-flop. A global register-type signal may switch it at run time between D behaviour, used to load, and T or JK behaviour, used to count.

The cell runs entirely on one system clock. No term ever clocks a flop directly. The selected cell-clock source is sampled each system cycle, its polarity is applied, and a low-to-high transition of the adjusted value is an update event. The register changes on the system edge where the event is first seen, using the data terms present at that edge. The preset and reset terms are level-sensitive and act on every system edge, whether or not a cell-clock event occurs. The cell has two function outputs and one output-enable output. There is no streaming data path, so every pin is a plain level with no valid/ready handshake.

Top module: `lcc_cell`

## Requirements
- R1: While `rst_n` is low the register holds 0. The edge history is set so that a cell-clock source already high (after polarity) at release produces no update until it has gone low and high again.
- R2: In D behaviour, an update event loads sum A into Q.
- R3: In T behaviour, an update event inverts Q when sum A is 1 and leaves Q unchanged when sum A is 0.
- R4: In JK behaviour, J is sum A and K is sum B, with K forced to 0 when sum B is claimed as preset. On an update event J/K = 1/1 inverts Q, 0/0 holds, 1/0 sets Q to 1, and 0/1 clears Q to 0.
- R5: `cfg_mode` codes are 0 = D, 1 = T, 2 = JK and 3 = D. When `cfg_dyn` is 1 and `glb_regtype` is 0, the cell behaves as D regardless of `cfg_mode`. When `glb_regtype` is 1, it uses `cfg_mode`. When `cfg_dyn` is 0, `glb_regtype` has no effect.
- R6: `cfg_clk_src` codes are 0 = `glb_clk`, 1 = sum C, 2 = sum D and 3 = `glb_clk`. With `cfg_clk_inv` = 1 the source is inverted before edge detection. Q changes only on the system edge where the adjusted source is 1 and was 0 at the previous system edge.
- R7: Clear is `glb_reset`, ORed with sum C when `cfg_c_reset` = 1 and sum C is not the clock source. Set is `glb_preset`, ORed with sum B when `cfg_b_preset` = 1. Clear forces Q to 0 at the next system edge. Otherwise set forces Q to 1. Both override any update event.
- R8: Each function output i takes its select from `cfg_out_sel[2i+1:2i]`, with 0 = Q, 1 = sum A, 2 = sum B and 3 = sum C. A sum claimed for a control role reads 0 on a function output: B when `cfg_b_preset` = 1, and C when it is the clock source or `cfg_c_reset` = 1.
- R9: `oe` equals sum D, except that it is held at 1 while sum D is the clock source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| sum_a | input | 1 | Sum term A from the array |
| sum_b | input | 1 | Sum term B from the array |
| sum_c | input | 1 | Sum term C from the array |
| sum_d | input | 1 | Sum term D from the array |
| glb_clk | input | 1 | Global cell clock |
| glb_preset | input | 1 | Global preset |
| glb_reset | input | 1 | Global reset |
| glb_regtype | input | 1 | Run-time register-type control |
| cfg_clk_src | input | 2 | Cell-clock source select |
| cfg_clk_inv | input | 1 | Cell-clock polarity invert |
| cfg_mode | input | 2 | Register behaviour |
| cfg_dyn | input | 1 | Enable run-time type switching |
| cfg_b_preset | input | 1 | Sum B used as preset |
| cfg_c_reset | input | 1 | Sum C used as reset |
| cfg_out_sel | input | 2*NUM_OUTS | Function output selects |
| fn_out | output | NUM_OUTS | Function outputs |
| oe | output | 1 | Output enable for the attached I/O cell |

## Verification
The sweep covers every combination of clock source, polarity, mode, dynamic switching and control claims. It feeds pseudo-random sums and globals against an arithmetic model. Several corner cases get targeted checks.

- **Source high at reset release.** A design that cleared its edge history would take a false update here.
- **Sum C as both clock and reset.** A design that let the reset win would clear Q on every clock pulse.
- **Claimed terms on a function output.** A design that leaked a claimed term would show preset or clock activity as data.
- **Clear and set at once.** A design with the wrong priority would leave Q at 1 instead of 0.

// File: rtl/lcc_pkg.sv
package lcc_pkg;
  localparam int SEL_W  = 2;
  localparam int MODE_W = 2;
  localparam int SRC_W  = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_D   = 2'd0,
    MODE_T   = 2'd1,
    MODE_JK  = 2'd2,
    MODE_D2  = 2'd3
  } mode_e;

  typedef enum logic [SRC_W-1:0] {
    SRC_GLB  = 2'd0,
    SRC_SUMC = 2'd1,
    SRC_SUMD = 2'd2,
    SRC_GLB2 = 2'd3
  } src_e;

  typedef enum logic [SEL_W-1:0] {
    OSEL_Q = 2'd0,
    OSEL_A = 2'd1,
    OSEL_B = 2'd2,
    OSEL_C = 2'd3
  } osel_e;

  typedef struct packed {
    logic clr;
    logic set;
    logic j;
    logic k;
  } ctl_t;
endpackage

// File: rtl/lcc_route.sv
module lcc_route
  import lcc_pkg::*;
(
  input  logic             sum_a,
  input  logic             sum_b,
  input  logic             sum_c,
  input  logic             sum_d,
  input  logic             glb_preset,
  input  logic             glb_reset,
  input  logic [SRC_W-1:0] cfg_clk_src,
  input  logic             cfg_b_preset,
  input  logic             cfg_c_reset,
  output ctl_t             ctl,
  output logic             comb_a,
  output logic             comb_b,
  output logic             comb_c,
  output logic             oe
);
  src_e src;
  logic c_is_clk;
  logic d_is_clk;
  logic c_claimed;

  always_comb begin
    src       = src_e'(cfg_clk_src);
    c_is_clk  = (src == SRC_SUMC);
    d_is_clk  = (src == SRC_SUMD);
    c_claimed = c_is_clk | cfg_c_reset;

    ctl.j   = sum_a;
    ctl.k   = cfg_b_preset ? 1'b0 : sum_b;
    ctl.set = glb_preset | (cfg_b_preset & sum_b);
    ctl.clr = glb_reset | (cfg_c_reset & ~c_is_clk & sum_c);

    comb_a  = sum_a;
    comb_b  = cfg_b_preset ? 1'b0 : sum_b;
    comb_c  = c_claimed ? 1'b0 : sum_c;
    oe      = d_is_clk ? 1'b1 : sum_d;
  end
endmodule

// File: rtl/lcc_clkdet.sv
module lcc_clkdet
  import lcc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             glb_clk,
  input  logic             sum_c,
  input  logic             sum_d,
  input  logic [SRC_W-1:0] cfg_clk_src,
  input  logic             cfg_clk_inv,
  output logic             upd
);
  logic raw;
  logic adj;
  logic prev_q;

  always_comb begin
    unique case (src_e'(cfg_clk_src))
      SRC_SUMC: raw = sum_c;
      SRC_SUMD: raw = sum_d;
      default:  raw = glb_clk;
    endcase
    adj = raw ^ cfg_clk_inv;
    upd = adj & ~prev_q;
  end

  // History starts high so a source already active at release is not an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= adj;
  end

  // R6
  single_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> !upd);
endmodule

// File: rtl/lcc_core.sv
module lcc_core
  import lcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  ctl_t              ctl,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic              cfg_dyn,
  input  logic              glb_regtype,
  output logic              q
);
  mode_e eff;
  logic  nxt;

  always_comb begin
    if (cfg_dyn && !glb_regtype) eff = MODE_D;
    else                         eff = mode_e'(cfg_mode);
    unique case (eff)
      MODE_T:  nxt = q ^ ctl.j;
      MODE_JK: nxt = (ctl.j & ~q) | (~ctl.k & q);
      default: nxt = ctl.j;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= 1'b0;
    else if (ctl.clr) q <= 1'b0;
    else if (ctl.set) q <= 1'b1;
    else if (upd)     q <= nxt;
  end

  // R7
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.clr |=> !q);
  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.clr && ctl.set) |=> q);
  // R6
  hold_no_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && !ctl.clr && !ctl.set) |=> $stable(q));
  // R3
  t_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !ctl.clr && !ctl.set && eff == MODE_T && ctl.j) |=> (q != $past(q)));
endmodule

// File: rtl/lcc_cell.sv
module lcc_cell
  import lcc_pkg::*;
#(
  parameter int NUM_OUTS = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sum_a,
  input  logic                      sum_b,
  input  logic                      sum_c,
  input  logic                      sum_d,
  input  logic                      glb_clk,
  input  logic                      glb_preset,
  input  logic                      glb_reset,
  input  logic                      glb_regtype,
  input  logic [1:0]                cfg_clk_src,
  input  logic                      cfg_clk_inv,
  input  logic [1:0]                cfg_mode,
  input  logic                      cfg_dyn,
  input  logic                      cfg_b_preset,
  input  logic                      cfg_c_reset,
  input  logic [2*NUM_OUTS-1:0]     cfg_out_sel,
  output logic [NUM_OUTS-1:0]       fn_out,
  output logic                      oe
);
  localparam int SELS_W = SEL_W * NUM_OUTS;

  ctl_t ctl;
  logic comb_a, comb_b, comb_c;
  logic upd;
  logic q;

  lcc_route u_route (
    .sum_a(sum_a), .sum_b(sum_b), .sum_c(sum_c), .sum_d(sum_d),
    .glb_preset(glb_preset), .glb_reset(glb_reset),
    .cfg_clk_src(cfg_clk_src), .cfg_b_preset(cfg_b_preset),
    .cfg_c_reset(cfg_c_reset), .ctl(ctl),
    .comb_a(comb_a), .comb_b(comb_b), .comb_c(comb_c), .oe(oe)
  );

  lcc_clkdet u_clkdet (
    .clk(clk), .rst_n(rst_n), .glb_clk(glb_clk), .sum_c(sum_c),
    .sum_d(sum_d), .cfg_clk_src(cfg_clk_src), .cfg_clk_inv(cfg_clk_inv),
    .upd(upd)
  );

  lcc_core u_core (
    .clk(clk), .rst_n(rst_n), .upd(upd), .ctl(ctl), .cfg_mode(cfg_mode),
    .cfg_dyn(cfg_dyn), .glb_regtype(glb_regtype), .q(q)
  );

  logic [SELS_W-1:0] sels;
  assign sels = cfg_out_sel;

  for (genvar i = 0; i < NUM_OUTS; i++) begin : g_out
    always_comb begin
      unique case (osel_e'(sels[i*SEL_W +: SEL_W]))
        OSEL_A:  fn_out[i] = comb_a;
        OSEL_B:  fn_out[i] = comb_b;
        OSEL_C:  fn_out[i] = comb_c;
        default: fn_out[i] = q;
      endcase
    end

    // R8
    claimed_c_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sels[i*SEL_W +: SEL_W] == OSEL_C && (cfg_c_reset || cfg_clk_src == SRC_SUMC))
        |-> !fn_out[i]);
  end

  // R9
  oe_clk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_clk_src == SRC_SUMD) |-> oe);
endmodule

// File: tb/sim_lcc_cell.sv
module sim_lcc_cell;
  localparam int PERIOD = 20;
  localparam int NO = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sa = 0, sb = 0, sc = 0, sd = 0;
  logic gclk = 0, gpre = 0, grst = 0, grt = 0;
  logic [1:0] src = 0, mode = 0;
  logic inv = 0, dyn = 0, bpre = 0, crst = 0;
  logic [2*NO-1:0] sel = 0;
  logic [NO-1:0] fo;
  logic oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic mq, mprev;
  string qtag;
  logic [15:0] lfsr = 16'hACE1;

  always #(PERIOD/2) clk = ~clk;

  lcc_cell #(.NUM_OUTS(NO)) u0 (
    .clk(clk), .rst_n(rst_n), .sum_a(sa), .sum_b(sb), .sum_c(sc), .sum_d(sd),
    .glb_clk(gclk), .glb_preset(gpre), .glb_reset(grst), .glb_regtype(grt),
    .cfg_clk_src(src), .cfg_clk_inv(inv), .cfg_mode(mode), .cfg_dyn(dyn),
    .cfg_b_preset(bpre), .cfg_c_reset(crst), .cfg_out_sel(sel),
    .fn_out(fo), .oe(oe)
  );

  task automatic chk(string tag, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  // Called at a falling edge; leaves the bench at a falling edge.
  task automatic do_reset();
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk); @(posedge clk); @(negedge clk);
    rst_n = 1'b1;
    mq = 1'b0;
    mprev = 1'b1;
  endtask

  // Model update from the requirements; inputs are already driven.
  task automatic model();
    logic raw, adj, edge_ev, clr, set, k, nq;
    logic [1:0] eff;
    raw = (src == 2'd1) ? sc : (src == 2'd2) ? sd : gclk;
    adj = raw ^ inv;
    edge_ev = adj & ~mprev;
    mprev = adj;
    clr = grst | (crst & (src != 2'd1) & sc);
    set = gpre | (bpre & sb);
    k = bpre ? 1'b0 : sb;
    eff = (dyn && !grt) ? 2'd0 : mode;
    case (eff)
      2'd1: nq = mq ^ sa;
      2'd2: nq = (sa && k) ? ~mq : (sa ? 1'b1 : (k ? 1'b0 : mq));
      default: nq = sa;
    endcase
    if (clr) begin mq = 1'b0; qtag = "R7"; end
    else if (set) begin mq = 1'b1; qtag = "R7"; end
    else if (edge_ev) begin
      mq = nq;
      qtag = dyn ? "R5" : (eff == 2'd1) ? "R3" : (eff == 2'd2) ? "R4" : "R2";
    end else qtag = "R6";
  endtask

  function automatic logic exp_out(logic [1:0] s);
    logic c_cl;
    c_cl = (src == 2'd1) | crst;
    case (s)
      2'd1: return sa;
      2'd2: return bpre ? 1'b0 : sb;
      2'd3: return c_cl ? 1'b0 : sc;
      default: return mq;
    endcase
  endfunction

  task automatic step();
    model();
    @(posedge clk);
    #2;
    for (int i = 0; i < NO; i++) begin
      logic [1:0] s;
      s = sel[2*i +: 2];
      chk((s == 2'd0) ? qtag : "R8", fo[i], exp_out(s), $sformatf("fn_out[%0d] sel %0d", i, s));
    end
    chk("R9", oe, (src == 2'd2) ? 1'b1 : sd, "oe");
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset state, source already high at release must not clock.
    src = 2'd0; inv = 0; mode = 2'd0; sel = 4'b0000; gclk = 1; sa = 1;
    do_reset();
    #1 chk("R1", fo[0], 1'b0, "Q after reset");
    step();
    chk("R1", fo[0], 1'b0, "no edge from high source at release");
    gclk = 0; step();
    gclk = 1; step();
    chk("R2", fo[0], 1'b1, "D load after fresh edge");

    // R7: sum C as clock and reset enable: clock wins, no clear.
    src = 2'd1; crst = 1; mode = 2'd0; sel = 4'b1100;
    do_reset();
    sa = 1; sc = 0; step();
    sc = 1; step();
    chk("R7", fo[0], 1'b1, "C clock not used as reset");
    chk("R8", fo[1], 1'b0, "claimed C reads 0");
    // R7: clear and set together, clear wins.
    grst = 1; gpre = 1; step();
    chk("R7", fo[0], 1'b0, "clear beats set");
    grst = 0; gpre = 0; crst = 0; sc = 0;

    // Full configuration sweep.
    for (int cfg = 0; cfg < 144; cfg++) begin
      mode = 2'(cfg % 3);
      dyn  = (cfg / 3) % 2;
      src  = 2'((cfg / 6) % 3);
      inv  = (cfg / 18) % 2;
      crst = (cfg / 36) % 2;
      bpre = (cfg / 72) % 2;
      sel  = {2'(cfg / 4), 2'(cfg)};
      if (cfg % 9 == 0) mode = 2'd3;
      do_reset();
      for (int n = 0; n < 24; n++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        sa = lfsr[0]; sb = lfsr[1] & lfsr[6]; sc = lfsr[2]; sd = lfsr[3];
        gclk = lfsr[4]; grt = lfsr[5];
        grst = (lfsr[9:7] == 3'd0);
        gpre = (lfsr[12:10] == 3'd0);
        if (crst && src != 2'd1) sc = lfsr[2] & lfsr[13];
        step();
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule